// File: doc/BRIEF.md
# Signed Word Divider with Overflow Forcing

This unit divides one signed 32-bit word by another for an execute stage. A one-cycle `start` pulse presents the dividend, the divisor and two option flags: one asks for an overflow report, the other asks for condition bits derived from the result. When the work finishes, the unit raises `done` for one cycle. The quotient, the overflow flag and the three condition bits are valid in that cycle and stay unchanged until the next accepted start.

Two operand pairs have no defined quotient: any value divided by zero, and the most negative word divided by minus one. The unit detects both cases in the first cycle after it accepts a start and does not run the iteration for them. It forces the quotient from the sign of the dividend instead. All other pairs go through a restoring radix-2 iteration on magnitudes, one quotient bit per clock. The sign is applied at the end.

Top module: `sdiv_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the unit clears `busy`, `done`, `ov`, `cond_lt`, `cond_gt`, `cond_eq` and `quotient`.
- R2: For pairs that do not overflow, `quotient` is the signed quotient truncated toward zero, as a 32-bit two's-complement value.
- R3: A divisor of zero counts as an overflow for any dividend, including zero.
- R4: A dividend of 0x80000000 with a divisor of 0xFFFFFFFF counts as an overflow.
- R5: On overflow, `quotient` is 0xFFFFFFFF if bit 31 of the dividend is 1 and 0x00000000 otherwise.
- R6: `ov` is 1 after completion only if the overflow-report flag was set at start and the pair overflowed. Otherwise it is 0.
- R7: If the condition flag was set at start, `cond_lt` is bit 31 of the quotient, `cond_eq` is 1 for a zero quotient, and `cond_gt` is 1 for a nonzero quotient with bit 31 clear. If the flag was clear, all three are 0.
- R8: Count the rising edge that samples `start` as edge 1. `done` rises after edge 2 for an overflow pair and after edge WIDTH+3 (edge 35) for every other pair.
- R9: `busy` is 1 from the edge that accepts `start` up to the edge that raises `done`. It is 0 in the `done` cycle.
- R10: A `start` pulse while `busy` is 1 is ignored. The running division completes with its original operands.
- R11: `done` is high for exactly one cycle. The quotient and flags keep their values until the next accepted start completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | 32 | Signed dividend, sampled with start |
| divisor | input | 32 | Signed divisor, sampled with start |
| ov_en | input | 1 | Request an overflow report, sampled with start |
| rec_en | input | 1 | Request condition bits, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | 32 | Result word |
| ov | output | 1 | Overflow report |
| cond_lt | output | 1 | Result negative |
| cond_gt | output | 1 | Result positive |
| cond_eq | output | 1 | Result zero |

## Verification
The bench tests the sign-forced overflow results: a negative dividend over zero, a nonnegative dividend over zero, zero over zero, and the most negative word over minus one. A design that tested only one overflow condition, or forced zero for every overflow, would return the wrong quotient or a silent `ov` here. The bench also tests the most negative word divided by 1 and by 2, and a positive value divided by the most negative word. These catch a magnitude path that loses the top bit or a sign fix-up that produces a negative zero. Finally, it sends a second start while a division is running and measures the exact done latency on both paths. A design that reloaded operands mid-run, or that ran the iteration for an overflow pair, would fail these checks.

// File: rtl/sdiv_pkg.sv
// Shared types for the signed divider.
// Assumes: the control states are encoded as a 2-bit enum.
package sdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CHK  = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIN  = 2'd3
    } sdiv_state_t;
endpackage

// File: rtl/sdiv_precheck.sv
// Operand inspection: finds the two undefined pairs, the quotient sign and
// the unsigned magnitudes.
// Assumes: operands are registered two's-complement words of WIDTH bits.
module sdiv_precheck #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] dvd,
    input  logic [WIDTH-1:0] dvs,
    output logic             ovf,
    output logic             neg_q,
    output logic [WIDTH-1:0] dvd_mag,
    output logic [WIDTH-1:0] dvs_mag
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    // Detect the zero-divisor and most-negative-over-minus-one pairs.
    always_comb begin
        ovf   = (dvs == '0) || (dvd == MOST_NEG && dvs == '1);
        neg_q = dvd[WIDTH-1] ^ dvs[WIDTH-1];
    end

    // Absolute values; MOST_NEG maps to itself, correct as unsigned.
    always_comb begin
        dvd_mag = dvd[WIDTH-1] ? (~dvd + 1'b1) : dvd;
        dvs_mag = dvs[WIDTH-1] ? (~dvs + 1'b1) : dvs;
    end
endmodule

// File: rtl/sdiv_iter.sv
// Restoring radix-2 divider on unsigned magnitudes, one quotient bit per step.
// Assumes: load and step are never high together; the divisor is nonzero.
module sdiv_iter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] dvd_mag,
    input  logic [WIDTH-1:0] dvs_mag,
    output logic [WIDTH-1:0] quot_mag
);
    logic [WIDTH-1:0] rem_q, qacc_q, dvs_q;
    logic [WIDTH:0]   rem_sh, diff;

    // Shift in the next dividend bit and trial-subtract the divisor.
    always_comb begin
        rem_sh = {rem_q, qacc_q[WIDTH-1]};
        diff   = rem_sh - {1'b0, dvs_q};
    end

    // Hold the partial remainder, the quotient accumulator and the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            qacc_q <= '0;
            dvs_q  <= '0;
        end else if (load) begin
            rem_q  <= '0;
            qacc_q <= dvd_mag;
            dvs_q  <= dvs_mag;
        end else if (step) begin
            if (!diff[WIDTH]) begin
                rem_q  <= diff[WIDTH-1:0];
                qacc_q <= {qacc_q[WIDTH-2:0], 1'b1};
            end else begin
                rem_q  <= rem_sh[WIDTH-1:0];
                qacc_q <= {qacc_q[WIDTH-2:0], 1'b0};
            end
        end
    end

    assign quot_mag = qacc_q;
endmodule

// File: rtl/sdiv_flags.sv
// Condition-bit generator for a signed result word.
// Assumes: all bits read zero when the record request is clear.
module sdiv_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res,
    input  logic             rec,
    output logic             lt,
    output logic             gt,
    output logic             eq
);
    // Classify the result as negative, positive or zero.
    always_comb begin
        lt = rec && res[WIDTH-1];
        eq = rec && (res == '0);
        gt = rec && !res[WIDTH-1] && (res != '0);
    end
endmodule

// File: rtl/sdiv_unit.sv
// Sequential signed divider with forced results for the undefined pairs.
// Assumes: start is a one-cycle pulse; operands and options are valid with it.
module sdiv_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    input  logic             ov_en,
    input  logic             rec_en,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic             ov,
    output logic             cond_lt,
    output logic             cond_gt,
    output logic             cond_eq
);
    import sdiv_pkg::*;

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    sdiv_state_t      state;
    logic [WIDTH-1:0] dvd_r, dvs_r;
    logic             oven_r, rec_r;
    logic [CNT_W-1:0] cnt;
    logic             ovf, neg_q;
    logic [WIDTH-1:0] dvd_mag, dvs_mag, quot_mag, res_next;
    logic             f_lt, f_gt, f_eq;

    sdiv_precheck #(.WIDTH(WIDTH)) u_pre (
        .dvd(dvd_r), .dvs(dvs_r), .ovf(ovf), .neg_q(neg_q),
        .dvd_mag(dvd_mag), .dvs_mag(dvs_mag)
    );

    sdiv_iter #(.WIDTH(WIDTH)) u_iter (
        .clk(clk), .rst_n(rst_n),
        .load(state == ST_CHK && !ovf), .step(state == ST_RUN),
        .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .quot_mag(quot_mag)
    );

    // Pick the result word: forced by dividend sign, or the signed quotient.
    always_comb begin
        if (state == ST_CHK)
            res_next = dvd_r[WIDTH-1] ? '1 : '0;
        else
            res_next = neg_q ? (~quot_mag + 1'b1) : quot_mag;
    end

    sdiv_flags #(.WIDTH(WIDTH)) u_flags (
        .res(res_next), .rec(rec_r), .lt(f_lt), .gt(f_gt), .eq(f_eq)
    );

    // Control sequence, operand capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dvd_r    <= '0;
            dvs_r    <= '0;
            oven_r   <= 1'b0;
            rec_r    <= 1'b0;
            cnt      <= '0;
            done     <= 1'b0;
            quotient <= '0;
            ov       <= 1'b0;
            cond_lt  <= 1'b0;
            cond_gt  <= 1'b0;
            cond_eq  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    dvd_r  <= dividend;
                    dvs_r  <= divisor;
                    oven_r <= ov_en;
                    rec_r  <= rec_en;
                    state  <= ST_CHK;
                end
                ST_CHK: if (ovf) begin
                    quotient <= res_next;
                    ov       <= oven_r;
                    cond_lt  <= f_lt;
                    cond_gt  <= f_gt;
                    cond_eq  <= f_eq;
                    done     <= 1'b1;
                    state    <= ST_IDLE;
                end else begin
                    cnt   <= '0;
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FIN;
                end
                ST_FIN: begin
                    quotient <= res_next;
                    ov       <= 1'b0;
                    cond_lt  <= f_lt;
                    cond_gt  <= f_gt;
                    cond_eq  <= f_eq;
                    done     <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sdiv_unit_chk.sv
// Temporal checks on the divider's ports, attached by bind.
// Assumes: rst_n is held low for at least one edge at the start.
module sdiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic             ov,
    input logic             cond_lt,
    input logic             cond_gt,
    input logic             cond_eq
);
    // R9: an accepted start makes the unit busy.
    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9: busy is low in the done cycle.
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: done lasts one cycle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the quotient changes only together with done.
    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient));

    // R5: a reported overflow carries one of the two forced patterns.
    a_r5_forced_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ov) |-> (quotient == '0 || quotient == '1));

    // R7: at most one condition bit is set.
    a_r7_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cond_lt, cond_gt, cond_eq}));
endmodule

bind sdiv_unit sdiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .quotient(quotient), .ov(ov), .cond_lt(cond_lt), .cond_gt(cond_gt),
    .cond_eq(cond_eq)
);

// File: tb/sdiv_unit_test.sv
module sdiv_unit_test;
    localparam int W = 32;
    localparam int NV = 16;
    // each entry: {dividend, divisor, expected quotient, expected overflow}
    localparam logic [3*W:0] VEC [NV] = '{
        {32'd100,        32'd7,          32'd14,         1'b0},
        {32'hFFFFFF9C,   32'd7,          32'hFFFFFFF2,   1'b0},
        {32'd100,        32'hFFFFFFF9,   32'hFFFFFFF2,   1'b0},
        {32'hFFFFFF9C,   32'hFFFFFFF9,   32'd14,         1'b0},
        {32'd7,          32'd100,        32'd0,          1'b0},
        {32'h7FFFFFFF,   32'd1,          32'h7FFFFFFF,   1'b0},
        {32'h80000000,   32'd1,          32'h80000000,   1'b0},
        {32'h80000000,   32'd2,          32'hC0000000,   1'b0},
        {32'h80000000,   32'h80000000,   32'd1,          1'b0},
        {32'h7FFFFFFF,   32'h80000000,   32'd0,          1'b0},
        {32'hFFFFFFFF,   32'd2,          32'd0,          1'b0},
        {32'h80000000,   32'hFFFFFFFF,   32'hFFFFFFFF,   1'b1},
        {32'd5,          32'd0,          32'd0,          1'b1},
        {32'hFFFFFFFB,   32'd0,          32'hFFFFFFFF,   1'b1},
        {32'd0,          32'd0,          32'd0,          1'b1},
        {32'h80000000,   32'd0,          32'hFFFFFFFF,   1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ov_en = 1'b0, rec_en = 1'b0;
    logic [W-1:0] dividend = '0, divisor = '0;
    logic busy, done, ov, cond_lt, cond_gt, cond_eq;
    logic [W-1:0] quotient;
    int checks = 0, fails = 0, lat = 0;

    always #2 clk = ~clk;

    sdiv_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .ov_en(ov_en), .rec_en(rec_en), .busy(busy),
        .done(done), .quotient(quotient), .ov(ov), .cond_lt(cond_lt),
        .cond_gt(cond_gt), .cond_eq(cond_eq)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch one division and wait for done; lat counts edges from the start edge.
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic oe, input logic re);
        @(negedge clk);
        dividend = a; divisor = b; ov_en = oe; rec_en = re; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check("R9 busy after start", {31'd0, busy}, 32'd1);
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [2:0] conds(input logic [W-1:0] q, input logic re);
        if (!re) return 3'b000;
        return {q[W-1], !q[W-1] && q != 0, q == 0};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset busy", {31'd0, busy}, 32'd0);
        check("R1 reset done", {31'd0, done}, 32'd0);
        check("R1 reset flags", {28'd0, ov, cond_lt, cond_gt, cond_eq}, 32'd0);
        check("R1 reset quotient", quotient, 32'd0);
        rst_n = 1'b1;

        // Table walk: R2 normal quotients, R3/R4 overflow detection, R5 forcing.
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] a, b, eq;
            logic eo;
            {a, b, eq, eo} = VEC[i];
            run(a, b, 1'b1, 1'b1);
            check(eo ? "R5 forced quotient" : "R2 quotient", quotient, eq);
            check(b == 0 ? "R3 overflow flag" : "R4 overflow flag", {31'd0, ov}, {31'd0, eo});
            check("R7 condition bits", {29'd0, cond_lt, cond_gt, cond_eq}, {29'd0, conds(eq, 1'b1)});
            check("R8 latency", lat, eo ? 2 : W + 3);
            check("R9 busy low at done", {31'd0, busy}, 32'd0);
            @(negedge clk);
            check("R11 done one cycle", {31'd0, done}, 32'd0);
            check("R11 quotient held", quotient, eq);
        end

        // R6: overflow not reported when the request is clear.
        run(32'hFFFFFFF0, 32'd0, 1'b0, 1'b1);
        check("R6 ov masked", {31'd0, ov}, 32'd0);
        check("R5 forced with ov masked", quotient, 32'hFFFFFFFF);
        // R6: normal pair with request set gives no overflow.
        run(32'd9, 32'd3, 1'b1, 1'b0);
        check("R6 ov clear on normal", {31'd0, ov}, 32'd0);
        // R7: condition bits zero when the record request is clear.
        check("R7 conds off", {29'd0, cond_lt, cond_gt, cond_eq}, 32'd0);
        check("R2 quotient 9/3", quotient, 32'd3);
        run(32'd0, 32'h80000000, 1'b0, 1'b1);
        check("R7 eq on zero", {29'd0, cond_lt, cond_gt, cond_eq}, 32'd1);

        // R10: a start during a run does not disturb it.
        @(negedge clk);
        dividend = 32'd100; divisor = 32'd7; ov_en = 1'b1; rec_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        dividend = 32'hFFFFFFFF; divisor = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R10 quotient unaffected", quotient, 32'd14);
        check("R10 no overflow", {31'd0, ov}, 32'd0);
        repeat (3) @(negedge clk);
        check("R10 unit idle afterwards", {31'd0, busy}, 32'd0);
        check("R11 held after idle", quotient, 32'd14);

        // R1: reset in the middle of a run clears everything.
        run(32'hFFFFFFFF, 32'd0, 1'b1, 1'b1);
        @(negedge clk);
        dividend = 32'd50; divisor = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run busy", {31'd0, busy}, 32'd0);
        check("R1 mid-run outputs", {quotient[3:0], ov, cond_lt, cond_gt, cond_eq}, 8'd0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule